// File: doc/BRIEF.md
# Long-Timeout Watchdog Power-Cycle Sequencer

This block is a slow, second-line watchdog. It runs next to a faster watchdog and catches software that keeps servicing the fast one by mistake. Software must change the level of the kick input (either direction) before a selectable timeout runs out. If the timeout runs out, a single reset pulse is not enough. The block runs a full recovery. It asserts the active-low reset output and waits. It then drops every regulator enable for a power-off interval. Next it turns the regulators back on one at a time, in a fixed order with a fixed gap between them. Last, it keeps reset asserted for a final interval and then releases it.

An undervoltage request from an external monitor also drives the reset output low while the request is present. The timeout counter is held at zero during that request and starts counting again only once reset is released. A 3-bit code picks one of seven timeouts, each a power-of-two multiple of a base count. The eighth code switches this watchdog off. A status flag shows that the most recent reset came from this watchdog. The next kick after the recovery clears it.

Top module: `lwd_pwrcycle`

## Requirements
- R1: After synchronous reset `rst_n` is 1, every bit of `reg_en` is 1 and `wd_stat` is 0.
- R2: For `tsel` code c in 0..6 the timeout is L = BASE·2^c cycles. The timeout counter is cleared on a rising edge. With no further kick, `rst_n` goes low on the L-th rising edge after that clearing edge.
- R3: The counter is cleared by any change of the `kick` level in either direction, seen on a rising edge. A kick pulse that lasts one cycle counts as two clears.
- R4: `tsel` = 7 disables the watchdog. No recovery sequence starts, however long kicks are absent.
- R5: Every regulator enable stays high for T_PRE cycles after `rst_n` falls. Then all enables go low on the same edge. Regulator enables are never low while `rst_n` is high.
- R6: The first regulator is enabled T_OFF cycles after the enables dropped. This is the regulator whose index is in ORDER bits [7:0].
- R7: Step k enables the regulator whose index is in ORDER bits [8k+7:8k]. It happens k·T_GAP cycles after the first enable. At most one enable rises per cycle.
- R8: `rst_n` rises T_FIN cycles after the last regulator is enabled. The timeout counter restarts from zero on that edge.
- R9: While a recovery sequence runs, kicks are ignored. They do not change its timing and do not clear `wd_stat`.
- R10: `wd_stat` rises on the same edge on which a timeout pulls `rst_n` low. It is cleared by the first kick seen once the sequence has ended.
- R11: While `uv_req` is high, `rst_n` is low from the next edge on and the counter is held at zero. The regulator enables and `wd_stat` are not affected. The timeout is counted from the edge on which `rst_n` rises again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| kick | input | 1 | Synchronized watchdog service input; any level change clears the timer |
| uv_req | input | 1 | Undervoltage reset request, active high |
| tsel | input | 3 | Timeout code: 0..6 select BASE·2^code cycles, 7 disables |
| rst_n | output | 1 | Active-low system reset, registered |
| reg_en | output | NREG | Regulator enable lines, registered |
| wd_stat | output | 1 | High when the last recovery came from this watchdog |

## Verification
The bench exercises four patterns:
- **Disabled code with no kicks.** The bench waits a long time with the disable code set. This separates a disabled watchdog from one with a long timeout.
- **Repeated single-cycle kick pulses, then silence.** Pulses arrive more often than the timeout, then stop. This separates a counter that is cleared by both edges from one that is cleared by one edge only. The exact cycle of the reset fall then fixes the timeout length.
- **Timeout directly after a recovery, with a stray kick mid-sequence.** The bench changes the timeout code and lets a second timeout follow a recovery with no kick in between. This shows that counting restarts at reset release. The kick sent during the sequence shows whether kicks are ignored there.
- **Undervoltage pulse.** An undervoltage pulse arrives in the middle of a long timeout. This separates a counter that resumes at reset release from one that keeps running.

Every output change is compared against a queue of expected cycle stamps. A wrong order, gap or interval shows up as an early, late or unexpected event.

// File: rtl/lwd_pkg.sv
package lwd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_OFF,
    ST_UP,
    ST_FIN
  } lwd_state_t;

  localparam logic [2:0] TSEL_DISABLE = 3'd7;
  localparam int         RAIL_IDW     = 8;

endpackage

// File: rtl/lwd_timer.sv
module lwd_timer #(
  parameter int BASE = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       kick,
  input  logic       hold,
  input  logic [2:0] tsel,
  output logic       kick_edge,
  output logic       fire
);
  import lwd_pkg::*;

  localparam int MAXLIM = BASE << 6;
  localparam int CW     = $clog2(MAXLIM + 1);

  logic          kick_q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          armed;

  assign kick_edge = kick ^ kick_q;
  assign armed     = (tsel != TSEL_DISABLE);
  assign lim       = CW'(BASE) << tsel;
  assign fire      = armed && !hold && !kick_edge && (cnt >= lim - CW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      kick_q <= kick;
      cnt    <= '0;
    end else begin
      kick_q <= kick;
      if (hold || kick_edge || !armed || fire) cnt <= '0;
      else                                     cnt <= cnt + CW'(1);
    end
  end

  // R3
  kick_clear_chk: assert property (@(posedge clk) disable iff (rst)
    kick_edge |=> (cnt == '0));

  // R4
  off_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (tsel == TSEL_DISABLE) |=> (cnt == '0));

endmodule

// File: rtl/lwd_seq.sv
module lwd_seq #(
  parameter int                            NREG  = 3,
  parameter logic [lwd_pkg::RAIL_IDW*NREG-1:0] ORDER = {8'd2, 8'd0, 8'd1},
  parameter int                            T_PRE = 8,
  parameter int                            T_OFF = 24,
  parameter int                            T_GAP = 4,
  parameter int                            T_FIN = 12
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        fire,
  input  logic                        kick_edge,
  input  logic                        uv,
  output logic                        busy,
  output logic                        rst_n_o,
  output logic                        stat_o,
  output logic                        rail_clr,
  output logic                        rail_step,
  output logic [lwd_pkg::RAIL_IDW-1:0] rail_sel
);
  import lwd_pkg::*;

  localparam int TM1  = (T_PRE > T_OFF) ? T_PRE : T_OFF;
  localparam int TM2  = (T_GAP > T_FIN) ? T_GAP : T_FIN;
  localparam int TMAX = (TM1 > TM2) ? TM1 : TM2;
  localparam int SW   = $clog2(TMAX + 1);
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  localparam logic [SW-1:0]   PRE_LAST = SW'(T_PRE - 1);
  localparam logic [SW-1:0]   OFF_LAST = SW'(T_OFF - 1);
  localparam logic [SW-1:0]   GAP_LAST = SW'(T_GAP - 1);
  localparam logic [SW-1:0]   FIN_LAST = SW'(T_FIN - 1);
  localparam logic [IDXW-1:0] IDX_LAST = IDXW'(NREG - 1);

  lwd_state_t      st;
  logic [SW-1:0]   sc;
  logic [IDXW-1:0] idx;
  logic            rn_q;
  logic            stat_q;

  assign busy    = (st != ST_IDLE);
  assign rst_n_o = rn_q;
  assign stat_o  = stat_q;

  always_comb begin
    rail_clr  = (st == ST_PRE) && (sc == PRE_LAST);
    rail_step = ((st == ST_OFF) && (sc == OFF_LAST)) ||
                ((st == ST_UP)  && (sc == GAP_LAST));
    rail_sel  = (st == ST_OFF) ? ORDER[RAIL_IDW-1:0]
                               : ORDER[idx*RAIL_IDW +: RAIL_IDW];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      sc     <= '0;
      idx    <= '0;
      rn_q   <= 1'b1;
      stat_q <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          rn_q <= !uv;
          sc   <= '0;
          if (fire) begin
            st     <= ST_PRE;
            rn_q   <= 1'b0;
            stat_q <= 1'b1;
          end else if (kick_edge) begin
            stat_q <= 1'b0;
          end
        end
        ST_PRE: begin
          if (sc == PRE_LAST) begin
            st <= ST_OFF;
            sc <= '0;
          end else sc <= sc + SW'(1);
        end
        ST_OFF: begin
          if (sc == OFF_LAST) begin
            st  <= (NREG == 1) ? ST_FIN : ST_UP;
            sc  <= '0;
            idx <= IDXW'(1);
          end else sc <= sc + SW'(1);
        end
        ST_UP: begin
          if (sc == GAP_LAST) begin
            sc <= '0;
            if (idx == IDX_LAST) st <= ST_FIN;
            else                 idx <= idx + IDXW'(1);
          end else sc <= sc + SW'(1);
        end
        ST_FIN: begin
          if (sc == FIN_LAST) begin
            st   <= ST_IDLE;
            sc   <= '0;
            rn_q <= !uv;
          end else sc <= sc + SW'(1);
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R9
  seq_stat_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> stat_q);

  // R10
  stat_with_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(stat_q) |-> $fell(rn_q));

endmodule

// File: rtl/lwd_rail_en.sv
module lwd_rail_en #(
  parameter int NREG = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clr,
  input  logic                        step,
  input  logic [lwd_pkg::RAIL_IDW-1:0] sel,
  output logic [NREG-1:0]             en
);
  import lwd_pkg::*;

  logic [NREG-1:0] en_q;

  for (genvar i = 0; i < NREG; i++) begin : g_rail
    always_ff @(posedge clk) begin
      if (rst)                                 en_q[i] <= 1'b1;
      else if (clr)                            en_q[i] <= 1'b0;
      else if (step && sel == RAIL_IDW'(i))    en_q[i] <= 1'b1;
    end
  end

  assign en = en_q;

  // R7
  one_rail_step_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(en_q) |-> ($countones(en_q & ~$past(en_q)) <= 1));

endmodule

// File: rtl/lwd_pwrcycle.sv
module lwd_pwrcycle #(
  parameter int                            NREG  = 3,
  parameter int                            BASE  = 16,
  parameter logic [lwd_pkg::RAIL_IDW*NREG-1:0] ORDER = {8'd2, 8'd0, 8'd1},
  parameter int                            T_PRE = 8,
  parameter int                            T_OFF = 24,
  parameter int                            T_GAP = 4,
  parameter int                            T_FIN = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            kick,
  input  logic            uv_req,
  input  logic [2:0]      tsel,
  output logic            rst_n,
  output logic [NREG-1:0] reg_en,
  output logic            wd_stat
);
  import lwd_pkg::*;

  logic                kick_edge;
  logic                fire;
  logic                busy;
  logic                hold;
  logic                rail_clr;
  logic                rail_step;
  logic [RAIL_IDW-1:0] rail_sel;

  assign hold = uv_req || busy || !rst_n;

  lwd_timer #(.BASE(BASE)) u_timer (
    .clk(clk), .rst(rst), .kick(kick), .hold(hold), .tsel(tsel),
    .kick_edge(kick_edge), .fire(fire)
  );

  lwd_seq #(
    .NREG(NREG), .ORDER(ORDER), .T_PRE(T_PRE), .T_OFF(T_OFF),
    .T_GAP(T_GAP), .T_FIN(T_FIN)
  ) u_seq (
    .clk(clk), .rst(rst), .fire(fire), .kick_edge(kick_edge), .uv(uv_req),
    .busy(busy), .rst_n_o(rst_n), .stat_o(wd_stat),
    .rail_clr(rail_clr), .rail_step(rail_step), .rail_sel(rail_sel)
  );

  lwd_rail_en #(.NREG(NREG)) u_rails (
    .clk(clk), .rst(rst), .clr(rail_clr), .step(rail_step),
    .sel(rail_sel), .en(reg_en)
  );

  // R5
  rails_off_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
    (reg_en != {NREG{1'b1}}) |-> !rst_n);

  // R8
  release_rails_on_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_n) |-> (&reg_en));

  // R11
  uv_holds_reset_chk: assert property (@(posedge clk) disable iff (rst)
    $past(uv_req) |-> !rst_n);

endmodule

// File: tb/lwd_pwrcycle_tb.sv
module lwd_pwrcycle_tb;

  localparam int T_PRE = 8;
  localparam int T_OFF = 24;
  localparam int T_GAP = 4;
  localparam int T_FIN = 12;
  localparam int BASE  = 16;

  typedef struct {
    int         stamp;
    logic [4:0] v;
    string      req;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       kick = 1'b0;
  logic       uv_req = 1'b0;
  logic [2:0] tsel = 3'd7;
  logic       rst_n;
  logic [2:0] reg_en;
  logic       wd_stat;

  int   cyc = 0;
  int   checks = 0;
  int   errors = 0;
  bit   mon_on = 1'b0;
  bit   done = 1'b0;
  ev_t  q[$];
  int   ord[3] = '{1, 0, 2};

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  lwd_pwrcycle u_dut (
    .clk(clk), .rst(rst), .kick(kick), .uv_req(uv_req), .tsel(tsel),
    .rst_n(rst_n), .reg_en(reg_en), .wd_stat(wd_stat)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push(input int stamp, input logic [4:0] v, input string req);
    ev_t e;
    e.stamp = stamp; e.v = v; e.req = req;
    q.push_back(e);
  endtask

  // expected events of one recovery starting at stamp s; returns release stamp
  task automatic push_seq(input int s, output int rel);
    logic [2:0] m;
    int t0;
    push(s, {1'b0, 3'b111, 1'b1}, "R2");
    push(s + T_PRE, {1'b0, 3'b000, 1'b1}, "R5");
    m = 3'b000;
    t0 = s + T_PRE + T_OFF;
    for (int k = 0; k < 3; k++) begin
      m[ord[k]] = 1'b1;
      push(t0 + k * T_GAP, {1'b0, m, 1'b1}, (k == 0) ? "R6" : "R7");
    end
    rel = t0 + 2 * T_GAP + T_FIN;
    push(rel, {1'b1, 3'b111, 1'b1}, "R8");
  endtask

  task automatic wait_until(input int stamp);
    while (cyc < stamp) @(negedge clk);
  endtask

  // scoreboard monitor
  logic [4:0] prev;
  always @(negedge clk) begin
    logic [4:0] cur;
    ev_t e;
    cur = {rst_n, reg_en, wd_stat};
    if (mon_on && cur !== prev) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected", int'(cur), -1);
      end else begin
        e = q.pop_front();
        check(e.stamp == cyc, e.req, cyc, e.stamp);
        check(e.v == cur, e.req, int'(cur), int'(e.v));
      end
    end
    prev = cur;
  end

  initial begin
    while (cyc < 60000 && !done) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int clr, s, rel, rel2, u, d;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    check(rst_n == 1'b1, "R1", rst_n, 1);
    check(reg_en == 3'b111, "R1", reg_en, 7);
    check(wd_stat == 1'b0, "R1", wd_stat, 0);
    mon_on = 1'b1;

    // R4: disabled, no kicks for a long time
    repeat (3000) @(negedge clk);
    check(rst_n == 1'b1, "R4", rst_n, 1);

    // R3 / R2: code 2, single-cycle kick pulses then silence
    tsel = 3'd2;
    kick = ~kick;
    clr = cyc + 1;
    for (int i = 0; i < 4; i++) begin
      repeat (38) @(negedge clk);
      kick = ~kick;
      @(negedge clk);
      kick = ~kick;
      clr = cyc + 1;
    end
    s = clr + (BASE << 2);
    push_seq(s, rel);
    // R9: kick while powered off
    wait_until(s + 20);
    kick = ~kick;
    wait_until(s + 30);
    check(wd_stat == 1'b1, "R9", wd_stat, 1);
    // R10: first kick after release clears status
    wait_until(rel + 10);
    kick = ~kick;
    push(rel + 11, {1'b1, 3'b111, 1'b0}, "R10");

    // R2 code 0 and R8 restart at release
    wait_until(rel + 30);
    tsel = 3'd0;
    kick = ~kick;
    s = cyc + 1 + BASE;
    push_seq(s, rel);
    push_seq(rel + BASE, rel2);
    wait_until(rel2 + 2);
    kick = ~kick;
    push(rel2 + 3, {1'b1, 3'b111, 1'b0}, "R10");
    wait_until(rel2 + 5);
    tsel = 3'd6;
    kick = ~kick;

    // R11: undervoltage pulse inside a long timeout
    u = rel2 + 100;
    wait_until(u);
    uv_req = 1'b1;
    push(u + 1, {1'b0, 3'b111, 1'b0}, "R11");
    d = u + 30;
    wait_until(d);
    uv_req = 1'b0;
    push(d + 1, {1'b1, 3'b111, 1'b0}, "R11");
    push_seq(d + 1 + (BASE << 6), rel);
    wait_until(rel + 1);
    tsel = 3'd7;
    repeat (100) @(negedge clk);
    check(q.size() == 0, "R11", q.size(), 0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule